// File: doc/BRIEF.md
# Read-Priority DRAM Request Scheduler with Write Escalation

This block sits in front of the command bus of an open-page DRAM controller. Read and write requests arrive on two separate valid/ready inputs. Each one carries a physical address, and the block splits that address into rank, bank, row and column fields. The requests wait in two age-ordered queues. In every cycle the scheduler offers exactly one command: an activate, a precharge, a column read or a column write. The command targets the request it judges most urgent. The command is consumed on a cycle where the downstream timing logic raises `cmdReady`.

Reads normally go ahead of writes, even writes that arrived earlier. When the write backlog climbs to a programmable threshold, the scheduler switches to draining writes. It keeps draining until the backlog falls to half that threshold. A table of open rows, one entry per bank, lets the scheduler favour requests that hit an open row. The same table lets it sequence the precharge and activate steps that a row conflict needs. A read whose address matches a pending write is held back until that write has issued.

Top module: `memsched_top`

## Requirements
- R1: After reset, `cmdValid` is 0 and both `rdReady` and `wrReady` are 1.
- R2: The address is decoded as column = bits [3:0], bank = bits [5:4], rank = bit 6 and row = bits [15:7]. Each offered command reports the rank, bank, row and column of the request it serves. At most one command is consumed per cycle.
- R3: A column command (read = 2, write = 3 on `cmdType`) is offered only when the request's row is open in its bank. The row stays open afterwards, so a later access to that row needs no activate.
- R4: When the write backlog is below the threshold and an eligible read is pending, reads are served before writes, including writes that arrived earlier.
- R5: Once the write queue count reaches `wrThresh` (and is nonzero), writes are served ahead of pending reads.
- R6: Write priority stays in force while the write count is above `wrThresh/2`. It ends once the count is at or below `wrThresh/2`.
- R7: Within the chosen class, a request hitting an open row is preferred over an older request that misses. Among equally suited requests, the oldest wins.
- R8: A request to a closed bank gets activate (`cmdType` 0). A request to a bank holding a different open row gets precharge (`cmdType` 1), then activate, then its column command.
- R9: Each queue holds 8 requests. A full queue drops its ready output, and a request offered while ready is low is not accepted.
- R10: A read whose full address equals a pending write is not served until that write has issued.
- R11: While `cmdReady` is low, the offered command is not consumed: the queues and the open-row table stay unchanged, and the same command remains offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdValid | input | 1 | Read request present |
| rdAddr | input | 16 | Read request physical address |
| rdReady | output | 1 | Read queue can accept |
| wrValid | input | 1 | Write request present |
| wrAddr | input | 16 | Write request physical address |
| wrReady | output | 1 | Write queue can accept |
| wrThresh | input | 4 | Write backlog level that starts write draining |
| cmdValid | output | 1 | A command is offered |
| cmdReady | input | 1 | Command bus takes the offered command this cycle |
| cmdType | output | 2 | 0 activate, 1 precharge, 2 read, 3 write |
| cmdRank | output | 1 | Target rank |
| cmdBank | output | 2 | Target bank within the rank |
| cmdRow | output | 9 | Row of the served request |
| cmdCol | output | 4 | Column of the served request |

## Verification
Two decisions can fall in the same cycle, and the interesting case is when they disagree. One is the choice of class, made by read priority or by write draining. The other is the choice inside a class, made by row-hit preference and age. The bench stalls the command bus while it loads mixed queues. Examples are an older row-conflicting read behind a younger hit, and a write backlog at threshold alongside a pending read to an idle bank. It then releases the bus and compares the exact sequence of offered commands, cycle by cycle, against an order worked out from the requirements. That sequence also shows the hysteresis point where the reads resume and the read-after-write hold on a matching address.

// File: rtl/memsched_pkg.sv
package memsched_pkg;

  localparam int ROW_W  = 9;
  localparam int RANK_W = 1;
  localparam int BANK_W = 2;
  localparam int COL_W  = 4;
  localparam int ADDR_W = ROW_W + RANK_W + BANK_W + COL_W;
  localparam int BIDX_W = RANK_W + BANK_W;
  localparam int NBANK  = 1 << BIDX_W;

  // Address layout, most significant first: row, rank, bank, column.
  typedef struct packed {
    logic [ROW_W-1:0]  row;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } req_t;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  // Strobes from control to datapath, already qualified by the bus handshake.
  typedef struct packed {
    logic              popRd;
    logic              popWr;
    logic              act;
    logic              pre;
    logic [BIDX_W-1:0] bankIdx;
    logic [ROW_W-1:0]  row;
  } stb_t;

endpackage

// File: rtl/memsched_queue.sv
module memsched_queue
  import memsched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       push,
  input  req_t                       pushEnt,
  input  logic                       pop,
  input  logic [$clog2(DEPTH)-1:0]   popIdx,
  output logic [DEPTH-1:0]           vld,
  output req_t                       ent [DEPTH],
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] cnt, cntNxt;
  req_t             mem [DEPTH];
  req_t             memNxt [DEPTH];

  // Entry 0 is always the oldest; removal compacts the younger entries down.
  always_comb begin
    memNxt = mem;
    cntNxt = cnt;
    if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) begin
        if (i >= int'(popIdx)) memNxt[i] = mem[i+1];
      end
      cntNxt = cnt - 1'b1;
    end
    if (push) begin
      memNxt[cntNxt[IDX_W-1:0]] = pushEnt;
      cntNxt = cntNxt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cntNxt;
  end

  always_ff @(posedge clk) begin
    mem <= memNxt;
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) vld[i] = (i < int'(cnt));
  end

  assign ent   = mem;
  assign count = cnt;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    push && !pop |-> int'(cnt) < DEPTH); // R9
  AST_POP_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> int'(popIdx) < int'(cnt)); // R9

endmodule

// File: rtl/memsched_datapath.sv
module memsched_datapath
  import memsched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       rdPush,
  input  req_t                       rdIn,
  input  logic                       wrPush,
  input  req_t                       wrIn,
  input  stb_t                       stb,
  input  logic [$clog2(DEPTH)-1:0]   popIdx,
  output logic [DEPTH-1:0]           rdVld,
  output logic [DEPTH-1:0]           wrVld,
  output logic [DEPTH-1:0]           rdHit,
  output logic [DEPTH-1:0]           wrHit,
  output logic [DEPTH-1:0]           rdOpen,
  output logic [DEPTH-1:0]           wrOpen,
  output logic [DEPTH-1:0]           rdBlk,
  output req_t                       rdQ [DEPTH],
  output req_t                       wrQ [DEPTH],
  output logic [$clog2(DEPTH+1)-1:0] rdCount,
  output logic [$clog2(DEPTH+1)-1:0] wrCount
);

  memsched_queue #(.DEPTH(DEPTH)) rdQueue_i (
    .clk(clk), .rstN(rstN), .push(rdPush), .pushEnt(rdIn),
    .pop(stb.popRd), .popIdx(popIdx), .vld(rdVld), .ent(rdQ), .count(rdCount)
  );

  memsched_queue #(.DEPTH(DEPTH)) wrQueue_i (
    .clk(clk), .rstN(rstN), .push(wrPush), .pushEnt(wrIn),
    .pop(stb.popWr), .popIdx(popIdx), .vld(wrVld), .ent(wrQ), .count(wrCount)
  );

  // Open-row table, one slot per (rank, bank).
  logic [NBANK-1:0] openVld;
  logic [ROW_W-1:0] openRow [NBANK];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        openVld <= '0;
    else if (stb.act) openVld[stb.bankIdx] <= 1'b1;
    else if (stb.pre) openVld[stb.bankIdx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (stb.act) openRow[stb.bankIdx] <= stb.row;
  end

  logic [BIDX_W-1:0] rdBidx [DEPTH];
  logic [BIDX_W-1:0] wrBidx [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign rdBidx[i] = {rdQ[i].rank, rdQ[i].bank};
    assign wrBidx[i] = {wrQ[i].rank, wrQ[i].bank};
    assign rdOpen[i] = openVld[rdBidx[i]];
    assign wrOpen[i] = openVld[wrBidx[i]];
    assign rdHit[i]  = rdOpen[i] && (openRow[rdBidx[i]] == rdQ[i].row);
    assign wrHit[i]  = wrOpen[i] && (openRow[wrBidx[i]] == wrQ[i].row);
  end

  // Read-after-write hazard: same full address as any queued write.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      rdBlk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (wrVld[j] && (wrQ[j] == rdQ[i])) rdBlk[i] = 1'b1;
      end
    end
  end

  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (!rstN)
    stb.act |-> !openVld[stb.bankIdx]); // R8
  AST_PRE_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    stb.pre |-> openVld[stb.bankIdx]); // R8
  AST_RD_HIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.popRd |-> rdHit[popIdx]); // R3
  AST_WR_HIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.popWr |-> wrHit[popIdx]); // R3
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    stb.popRd |-> !rdBlk[popIdx]); // R10
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.popRd, stb.popWr, stb.act, stb.pre}) <= 1); // R2

endmodule

// File: rtl/memsched_ctrl.sv
module memsched_ctrl
  import memsched_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [DEPTH-1:0]           rdVld,
  input  logic [DEPTH-1:0]           wrVld,
  input  logic [DEPTH-1:0]           rdHit,
  input  logic [DEPTH-1:0]           wrHit,
  input  logic [DEPTH-1:0]           rdOpen,
  input  logic [DEPTH-1:0]           wrOpen,
  input  logic [DEPTH-1:0]           rdBlk,
  input  req_t                       rdQ [DEPTH],
  input  req_t                       wrQ [DEPTH],
  input  logic [$clog2(DEPTH+1)-1:0] wrCount,
  input  logic                       wrPush,
  input  logic [$clog2(DEPTH+1)-1:0] wrThresh,
  input  logic                       cmdReady,
  output stb_t                       stb,
  output logic [$clog2(DEPTH)-1:0]   popIdx,
  output logic                       cmdValid,
  output cmd_e                       cmdType,
  output req_t                       cmdEnt
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  // Hit-first, then oldest (lowest index) among the eligible set.
  function automatic logic [IDX_W-1:0] pickIdx(input logic [DEPTH-1:0] elig,
                                               input logic [DEPTH-1:0] hit);
    logic [IDX_W-1:0] res;
    logic             found;
    res   = '0;
    found = 1'b0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (elig[i]) res = IDX_W'(i);
    end
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (elig[i] && hit[i]) begin
        res   = IDX_W'(i);
        found = 1'b1;
      end
    end
    if (!found) res = res;
    return res;
  endfunction

  logic             drainQ, drainNxt;
  logic [DEPTH-1:0] rdElig;
  logic             rdAny, wrAny, useWr;
  logic [IDX_W-1:0] rdPick, wrPick, selIdx;
  logic             selHit, selOpen, fire;
  req_t             selEnt;
  logic [CNT_W-1:0] wrCountNxt;

  assign rdElig = rdVld & ~rdBlk;
  assign rdAny  = |rdElig;
  assign wrAny  = |wrVld;
  assign rdPick = pickIdx(rdElig, rdHit);
  assign wrPick = pickIdx(wrVld, wrHit);

  // Class choice: writes when draining, otherwise only if no read can go.
  assign useWr   = wrAny && (drainQ || !rdAny);
  assign selIdx  = useWr ? wrPick : rdPick;
  assign selEnt  = useWr ? wrQ[wrPick] : rdQ[rdPick];
  assign selHit  = useWr ? wrHit[wrPick] : rdHit[rdPick];
  assign selOpen = useWr ? wrOpen[wrPick] : rdOpen[rdPick];

  assign cmdValid = rdAny || wrAny;
  assign fire     = cmdValid && cmdReady;
  assign cmdEnt   = selEnt;
  assign popIdx   = selIdx;

  always_comb begin
    if (selHit)       cmdType = useWr ? CMD_WR : CMD_RD;
    else if (selOpen) cmdType = CMD_PRE;
    else              cmdType = CMD_ACT;
  end

  always_comb begin
    stb.popRd   = fire && selHit && !useWr;
    stb.popWr   = fire && selHit && useWr;
    stb.act     = fire && !selHit && !selOpen;
    stb.pre     = fire && !selHit && selOpen;
    stb.bankIdx = {selEnt.rank, selEnt.bank};
    stb.row     = selEnt.row;
  end

  // Drain mode with hysteresis, evaluated on the count after this cycle.
  assign wrCountNxt = wrCount + {{(CNT_W-1){1'b0}}, wrPush}
                              - {{(CNT_W-1){1'b0}}, stb.popWr};

  always_comb begin
    if (drainQ) drainNxt = (wrCountNxt > (wrThresh >> 1));
    else        drainNxt = (wrCountNxt != '0) && (wrCountNxt >= wrThresh);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drainQ <= 1'b0;
    else       drainQ <= drainNxt;
  end

  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    stb.popWr && !drainQ |-> !rdAny); // R4
  AST_DRAIN_WR: assert property (@(posedge clk) disable iff (!rstN)
    drainQ && wrAny |-> !stb.popRd); // R5
  AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drainQ) |-> wrCount <= ($past(wrThresh) >> 1)); // R6

endmodule

// File: rtl/memsched_top.sv
module memsched_top
  import memsched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int THR_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdReady,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  output logic              wrReady,
  input  logic [THR_W-1:0]  wrThresh,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [1:0]        cmdType,
  output logic [RANK_W-1:0] cmdRank,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DEPTH-1:0] rdVld, wrVld, rdHit, wrHit, rdOpen, wrOpen, rdBlk;
  req_t             rdQ [DEPTH];
  req_t             wrQ [DEPTH];
  logic [CNT_W-1:0] rdCount, wrCount;
  logic             rdPush, wrPush;
  stb_t             stb;
  logic [IDX_W-1:0] popIdx;
  cmd_e             cmdTypeE;
  req_t             cmdEnt;

  assign rdReady = int'(rdCount) < DEPTH;
  assign wrReady = int'(wrCount) < DEPTH;
  assign rdPush  = rdValid && rdReady;
  assign wrPush  = wrValid && wrReady;

  memsched_datapath #(.DEPTH(DEPTH)) datapath_i (
    .clk(clk), .rstN(rstN),
    .rdPush(rdPush), .rdIn(req_t'(rdAddr)),
    .wrPush(wrPush), .wrIn(req_t'(wrAddr)),
    .stb(stb), .popIdx(popIdx),
    .rdVld(rdVld), .wrVld(wrVld), .rdHit(rdHit), .wrHit(wrHit),
    .rdOpen(rdOpen), .wrOpen(wrOpen), .rdBlk(rdBlk),
    .rdQ(rdQ), .wrQ(wrQ), .rdCount(rdCount), .wrCount(wrCount)
  );

  memsched_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .rdVld(rdVld), .wrVld(wrVld), .rdHit(rdHit), .wrHit(wrHit),
    .rdOpen(rdOpen), .wrOpen(wrOpen), .rdBlk(rdBlk),
    .rdQ(rdQ), .wrQ(wrQ), .wrCount(wrCount), .wrPush(wrPush),
    .wrThresh(CNT_W'(wrThresh)), .cmdReady(cmdReady),
    .stb(stb), .popIdx(popIdx), .cmdValid(cmdValid),
    .cmdType(cmdTypeE), .cmdEnt(cmdEnt)
  );

  assign cmdType = cmdTypeE;
  assign cmdRank = cmdEnt.rank;
  assign cmdBank = cmdEnt.bank;
  assign cmdRow  = cmdEnt.row;
  assign cmdCol  = cmdEnt.col;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady && !rdPush && !wrPush && $stable(wrThresh)
    |=> cmdValid && $stable(cmdType) && $stable(cmdBank) && $stable(cmdRank)
        && $stable(cmdRow) && $stable(cmdCol)); // R11

endmodule

// File: tb/memsched_top_tb_top.sv
`timescale 1ns/1ps
module memsched_top_tb_top;
  import memsched_pkg::*;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rdValid, wrValid, rdReady, wrReady;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [3:0]        wrThresh;
  logic              cmdValid, cmdReady;
  logic [1:0]        cmdType;
  logic [RANK_W-1:0] cmdRank;
  logic [BANK_W-1:0] cmdBank;
  logic [ROW_W-1:0]  cmdRow;
  logic [COL_W-1:0]  cmdCol;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  memsched_top dut_i (
    .clk(clk), .rstN(rstN),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdReady(rdReady),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrReady(wrReady),
    .wrThresh(wrThresh), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdType(cmdType), .cmdRank(cmdRank), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol)
  );

  function automatic logic [ADDR_W-1:0] mkAddr(int rk, int bk, int row, int col);
    return {ROW_W'(row), RANK_W'(rk), BANK_W'(bk), COL_W'(col)};
  endfunction

  task automatic checkBit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic resetDut(int thr);
    rstN = 1'b0; rdValid = 1'b0; wrValid = 1'b0; cmdReady = 1'b0;
    rdAddr = '0; wrAddr = '0; wrThresh = 4'(thr);
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic pushRd(int rk, int bk, int row, int col);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = mkAddr(rk, bk, row, col);
    @(posedge clk);
    #1 rdValid = 1'b0;
  endtask

  task automatic pushWr(int rk, int bk, int row, int col);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = mkAddr(rk, bk, row, col);
    @(posedge clk);
    #1 wrValid = 1'b0;
  endtask

  // One offered command per cycle; sampled mid-cycle.
  task automatic expectCmd(string tag, int t, int rk, int bk, int row, int col);
    @(negedge clk);
    checks++;
    if (!(cmdValid === 1'b1 && int'(cmdType) == t && int'(cmdRank) == rk &&
          int'(cmdBank) == bk && int'(cmdRow) == row && int'(cmdCol) == col)) begin
      errors++;
      $display("FAIL %s: actual v=%0b t=%0d rk=%0d bk=%0d row=%0d col=%0d expected v=1 t=%0d rk=%0d bk=%0d row=%0d col=%0d",
               tag, cmdValid, cmdType, cmdRank, cmdBank, cmdRow, cmdCol, t, rk, bk, row, col);
    end
  endtask

  task automatic expectIdle(string tag);
    @(negedge clk);
    checkBit(tag, cmdValid, 1'b0);
  endtask

  task automatic testReset();
    resetDut(8);
    @(negedge clk);
    checkBit("R1 cmdValid", cmdValid, 1'b0);
    checkBit("R1 rdReady", rdReady, 1'b1);
    checkBit("R1 wrReady", wrReady, 1'b1);
  endtask

  task automatic testReadFirst();
    resetDut(8);
    pushWr(1, 2, 5, 1);
    pushRd(1, 3, 7, 2);
    cmdReady = 1'b1;
    expectCmd("R4 R2 read bank first", 0, 1, 3, 7, 2);
    expectCmd("R4 R3 read column", 2, 1, 3, 7, 2);
    expectCmd("R8 write activate", 0, 1, 2, 5, 1);
    expectCmd("R3 write column", 3, 1, 2, 5, 1);
    expectIdle("R2 queues empty");
  endtask

  task automatic testHitAndAge();
    resetDut(8);
    pushRd(0, 0, 0, 0);
    cmdReady = 1'b1;
    expectCmd("R8 activate closed bank", 0, 0, 0, 0, 0);
    expectCmd("R3 read after activate", 2, 0, 0, 0, 0);
    @(posedge clk); #1 cmdReady = 1'b0;
    pushRd(0, 0, 1, 0);
    pushRd(0, 0, 0, 5);
    cmdReady = 1'b1;
    expectCmd("R7 R3 younger hit first", 2, 0, 0, 0, 5);
    expectCmd("R8 precharge on conflict", 1, 0, 0, 1, 0);
    expectCmd("R8 activate new row", 0, 0, 0, 1, 0);
    expectCmd("R8 column after activate", 2, 0, 0, 1, 0);
    @(posedge clk); #1 cmdReady = 1'b0;
    pushRd(0, 0, 1, 2);
    pushRd(0, 0, 1, 1);
    cmdReady = 1'b1;
    expectCmd("R7 R3 oldest hit first", 2, 0, 0, 1, 2);
    expectCmd("R7 next oldest hit", 2, 0, 0, 1, 1);
    expectIdle("R7 drained");
  endtask

  task automatic testDrain();
    resetDut(4);
    for (int c = 0; c < 4; c++) pushWr(0, 0, 3, c);
    pushRd(0, 1, 2, 6);
    cmdReady = 1'b1;
    expectCmd("R5 write activate ahead of read", 0, 0, 0, 3, 0);
    expectCmd("R5 write column", 3, 0, 0, 3, 0);
    expectCmd("R6 still draining above half", 3, 0, 0, 3, 1);
    expectCmd("R6 read resumes at half", 0, 0, 1, 2, 6);
    expectCmd("R6 read column", 2, 0, 1, 2, 6);
    expectCmd("R4 remaining write", 3, 0, 0, 3, 2);
    expectCmd("R4 last write", 3, 0, 0, 3, 3);
    expectIdle("R5 drained");
  endtask

  task automatic testRaw();
    resetDut(8);
    pushWr(0, 2, 4, 3);
    pushRd(0, 2, 4, 3);
    cmdReady = 1'b1;
    expectCmd("R10 write goes first", 0, 0, 2, 4, 3);
    expectCmd("R10 write column", 3, 0, 2, 4, 3);
    expectCmd("R10 read after write", 2, 0, 2, 4, 3);
    expectIdle("R10 drained");
  endtask

  task automatic testStall();
    resetDut(8);
    pushRd(1, 1, 9, 4);
    @(negedge clk);
    checkBit("R11 offered while stalled", cmdValid, 1'b1);
    repeat (3) @(posedge clk);
    expectCmd("R11 same command held", 0, 1, 1, 9, 4);
    @(posedge clk); #1 cmdReady = 1'b1;
    expectCmd("R11 activate not consumed earlier", 0, 1, 1, 9, 4);
    expectCmd("R11 read follows", 2, 1, 1, 9, 4);
    expectIdle("R11 drained");
  endtask

  task automatic testFull();
    resetDut(8);
    for (int c = 0; c < 8; c++) pushRd(0, 0, 0, c);
    @(negedge clk);
    checkBit("R9 read ready low when full", rdReady, 1'b0);
    checkBit("R9 write ready unaffected", wrReady, 1'b1);
    pushRd(0, 0, 0, 8);
    cmdReady = 1'b1;
    expectCmd("R9 activate", 0, 0, 0, 0, 0);
    for (int c = 0; c < 8; c++) expectCmd("R9 queued read", 2, 0, 0, 0, c);
    expectIdle("R9 extra read dropped");
  endtask

  initial begin
    testReset();
    testReadFirst();
    testHitAndAge();
    testDrain();
    testRaw();
    testStall();
    testFull();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule